// File: doc/BRIEF.md
# Wait-For-Interrupt Wake Controller

This block sits next to the issue stage of a processor core. When a wait-for-interrupt instruction commits, it holds instruction issue until some interrupt source is both pending and individually enabled. It then releases issue and reports how execution should continue. The wake test looks only at the per-source enable bits. It does not look at the global machine and supervisor enables, the delegation mask or the current privilege. An interrupt that is masked for taking can therefore still end the wait.

At the moment of release, the controller separately evaluates whether any armed source can be taken under the normal rules. If none can, it reports a plain fall-through to the wait PC plus 4. If one can, it flags a trap that the trap unit takes on the following instruction, so the saved epc is again the wait PC plus 4. Choosing which interrupt wins, and producing the trap vector, are left to the trap unit.

A registered clock-gate enable lets surrounding logic switch its clock off for the duration of the wait. A parameter reduces the whole controller to a no-op that never stalls.

Top module: `wfi_wake_ctrl`

## Requirements
- R1: The wake condition is true when at least one source has both its pending bit and its enable bit set. It does not depend on the global enables, the delegation mask or the privilege level.
- R2: If the wait commits while the wake condition is false, `stall_o` is 1 from the next cycle on, for as long as the wake condition stays false.
- R3: In the first cycle of a wait in which the wake condition is true, `stall_o` is 0 and `resume_valid_o` is 1 in that same cycle. After that cycle, the controller is idle.
- R4: If the wake condition is already true in the cycle the wait commits, then `resume_valid_o` is 1 in that cycle and `stall_o` stays 0 in the following cycle.
- R5: Whenever `resume_valid_o` is 1, `resume_pc_o` equals the committed wait PC plus 4, modulo 2^XLEN.
- R6: When `resume_valid_o` is 1, `resume_trap_o` is 1 exactly when some armed source can be taken. Privilege encoding is U=0, S=1, M=3. A source with its delegation bit at 0 can be taken when priv is not M, or when `m_gie_i` is 1. A source with its delegation bit at 1 can be taken when priv is U, or when priv is S and `s_gie_i` is 1. A delegated source is never taken in M.
- R7: A resume with `resume_trap_o` at 0 is a fall-through. `resume_trap_o` is never 1 while `resume_valid_o` is 0.
- R8: `clk_en_o` is 0 from the cycle after a stalling commit up to and including the wake cycle. It is 1 otherwise.
- R9: With `NOP_MODE`=1, `stall_o` is always 0 and `clk_en_o` is always 1. `resume_valid_o` follows `wfi_commit_i` in the same cycle, with the PC and trap flag as in R5 and R6.
- R10: While `rst` is 1, and in the cycle after it, `stall_o` is 0, `clk_en_o` is 1 and `resume_valid_o` is 0 when no commit is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_commit_i | input | 1 | Wait instruction commits this cycle |
| wfi_pc_i | input | XLEN | PC of the committing wait instruction |
| irq_pending_i | input | NUM_IRQ | Per-source pending bits |
| irq_enable_i | input | NUM_IRQ | Per-source enable bits |
| irq_deleg_i | input | NUM_IRQ | Per-source delegation to supervisor |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| stall_o | output | 1 | Hold instruction issue |
| clk_en_o | output | 1 | Registered clock-gate enable |
| resume_valid_o | output | 1 | Wait ends this cycle |
| resume_trap_o | output | 1 | Take a trap on the next instruction |
| resume_pc_o | output | XLEN | Resume PC and epc (wait PC + 4) |

## Verification
The bench wakes the controller with sources whose global enable is off, with delegated sources while in M, and in U. A design that gated wake with the global enables or delegation would stay stalled forever, and one that mixed the take rules into wake would trap where a fall-through is due. It commits a wait with a source already armed, to catch a spurious single stall cycle, and it commits at the top of the address space to catch a PC that does not wrap. It also holds a source pending but not enabled to show that no wake occurs. A random phase compares stall, clock enable, resume PC and trap flag against a behavioural model on every cycle, and a second instance covers the no-op variant.

// File: rtl/wfi_pkg.sv
package wfi_pkg;

    typedef enum logic [1:0] {
        PRIV_U    = 2'b00,
        PRIV_S    = 2'b01,
        PRIV_RSVD = 2'b10,
        PRIV_M    = 2'b11
    } priv_e;

    typedef struct packed {
        logic valid;
        logic trap;
    } resume_t;

    localparam int unsigned INSN_BYTES = 4;

    // Whether a single armed source may be taken under the global rules.
    function automatic logic source_open(input logic delegated, input priv_e p,
                                         input logic m_gie, input logic s_gie);
        logic open;
        if (delegated) begin
            open = (p == PRIV_U) || ((p == PRIV_S) && s_gie);
        end else begin
            open = (p != PRIV_M) || m_gie;
        end
        return open;
    endfunction

endpackage

// File: rtl/wfi_wake_detect.sv
module wfi_wake_detect #(
    parameter int unsigned NUM_IRQ = 16
) (
    input  logic [NUM_IRQ-1:0] pending_i,
    input  logic [NUM_IRQ-1:0] enable_i,
    output logic [NUM_IRQ-1:0] armed_o,
    output logic               wake_o
);
    // Local enables only: globals and delegation are deliberately absent.
    always_comb begin
        armed_o = pending_i & enable_i;
        wake_o  = |armed_o;
    end
endmodule

// File: rtl/wfi_take_eval.sv
module wfi_take_eval
    import wfi_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 16
) (
    input  logic [NUM_IRQ-1:0] armed_i,
    input  logic [NUM_IRQ-1:0] deleg_i,
    input  logic [1:0]         priv_i,
    input  logic               m_gie_i,
    input  logic               s_gie_i,
    output logic               take_o
);
    logic [NUM_IRQ-1:0] hit;
    priv_e              cur_priv;

    assign cur_priv = priv_e'(priv_i);

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
        assign hit[g] = armed_i[g] & source_open(deleg_i[g], cur_priv, m_gie_i, s_gie_i);
    end

    assign take_o = |hit;
endmodule

// File: rtl/wfi_wait_fsm.sv
module wfi_wait_fsm
    import wfi_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter bit          NOP_MODE = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            commit_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            wake_i,
    output logic            stall_o,
    output logic            clk_en_o,
    output logic            resume_valid_o,
    output logic [XLEN-1:0] resume_pc_o
);
    localparam bit          STALL_EN = !NOP_MODE;
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic            waiting_q, waiting_d;
    logic            clk_en_q;
    logic [XLEN-1:0] pc_q, pc_d;
    logic            enter, leave;

    always_comb begin
        enter     = STALL_EN && commit_i && !waiting_q && !wake_i;
        leave     = waiting_q && wake_i;
        waiting_d = enter ? 1'b1 : (leave ? 1'b0 : waiting_q);
        pc_d      = enter ? pc_i : pc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            waiting_q <= 1'b0;
            clk_en_q  <= 1'b1;
            pc_q      <= '0;
        end else begin
            waiting_q <= waiting_d;
            clk_en_q  <= !waiting_d;
            pc_q      <= pc_d;
        end
    end

    always_comb begin
        stall_o        = waiting_q && !wake_i;
        clk_en_o       = clk_en_q;
        resume_valid_o = leave || (commit_i && !waiting_q && (wake_i || NOP_MODE));
        resume_pc_o    = (waiting_q ? pc_q : pc_i) + STEP;
    end
endmodule

// File: rtl/wfi_wake_ctrl.sv
module wfi_wake_ctrl
    import wfi_pkg::*;
#(
    parameter int unsigned NUM_IRQ  = 16,
    parameter int unsigned XLEN     = 32,
    parameter bit          NOP_MODE = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wfi_commit_i,
    input  logic [XLEN-1:0]    wfi_pc_i,
    input  logic [NUM_IRQ-1:0] irq_pending_i,
    input  logic [NUM_IRQ-1:0] irq_enable_i,
    input  logic [NUM_IRQ-1:0] irq_deleg_i,
    input  logic               m_gie_i,
    input  logic               s_gie_i,
    input  logic [1:0]         priv_i,
    output logic               stall_o,
    output logic               clk_en_o,
    output logic               resume_valid_o,
    output logic               resume_trap_o,
    output logic [XLEN-1:0]    resume_pc_o
);
    logic [NUM_IRQ-1:0] armed;
    logic               wake;
    logic               take;
    resume_t            res;

    wfi_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_wake (
        .pending_i (irq_pending_i),
        .enable_i  (irq_enable_i),
        .armed_o   (armed),
        .wake_o    (wake)
    );

    wfi_take_eval #(.NUM_IRQ(NUM_IRQ)) u_take (
        .armed_i (armed),
        .deleg_i (irq_deleg_i),
        .priv_i  (priv_i),
        .m_gie_i (m_gie_i),
        .s_gie_i (s_gie_i),
        .take_o  (take)
    );

    wfi_wait_fsm #(.XLEN(XLEN), .NOP_MODE(NOP_MODE)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .commit_i       (wfi_commit_i),
        .pc_i           (wfi_pc_i),
        .wake_i         (wake),
        .stall_o        (stall_o),
        .clk_en_o       (clk_en_o),
        .resume_valid_o (res.valid),
        .resume_pc_o    (resume_pc_o)
    );

    assign res.trap       = res.valid && take;
    assign resume_valid_o = res.valid;
    assign resume_trap_o  = res.trap;
endmodule

// File: rtl/wfi_wake_ctrl_chk.sv
module wfi_wake_ctrl_chk #(
    parameter int unsigned NUM_IRQ  = 16,
    parameter int unsigned XLEN     = 32,
    parameter bit          NOP_MODE = 1'b0
) (
    input logic               clk,
    input logic               rst,
    input logic               wfi_commit_i,
    input logic [NUM_IRQ-1:0] irq_pending_i,
    input logic [NUM_IRQ-1:0] irq_enable_i,
    input logic               stall_o,
    input logic               clk_en_o,
    input logic               resume_valid_o,
    input logic               resume_trap_o
);
    logic any_armed;
    assign any_armed = |(irq_pending_i & irq_enable_i);

    // R2: a commit without wake leads to a stall that tracks the lack of wake
    a_r2_stall_after_commit: assert property (@(posedge clk) disable iff (rst)
        (wfi_commit_i && !any_armed && !stall_o && !NOP_MODE) |=> (stall_o == !any_armed));

    // R3: never stalled while a source is armed
    a_r3_release_on_wake: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> !any_armed);

    // R3: a stall that ends is matched by a resume in that cycle
    a_r3_resume_at_release: assert property (@(posedge clk) disable iff (rst)
        ($past(stall_o) && !stall_o) |-> resume_valid_o);

    // R4: commit with wake already true never stalls
    a_r4_no_stall_when_armed: assert property (@(posedge clk) disable iff (rst)
        (wfi_commit_i && any_armed && !stall_o) |=> !stall_o);

    // R7: trap only qualifies a resume
    a_r7_trap_needs_resume: assert property (@(posedge clk) disable iff (rst)
        resume_trap_o |-> resume_valid_o);

    // R8: clock gate is closed whenever issue is stalled
    a_r8_gate_closed_in_stall: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> !clk_en_o);

    // R9: no-op variant never stalls
    a_r9_nop_never_stalls: assert property (@(posedge clk) disable iff (rst)
        NOP_MODE |-> (!stall_o && clk_en_o));
endmodule

bind wfi_wake_ctrl wfi_wake_ctrl_chk #(
    .NUM_IRQ(NUM_IRQ), .XLEN(XLEN), .NOP_MODE(NOP_MODE)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .wfi_commit_i   (wfi_commit_i),
    .irq_pending_i  (irq_pending_i),
    .irq_enable_i   (irq_enable_i),
    .stall_o        (stall_o),
    .clk_en_o       (clk_en_o),
    .resume_valid_o (resume_valid_o),
    .resume_trap_o  (resume_trap_o)
);

// File: tb/tb_wfi_wake_ctrl.sv
module tb_wfi_wake_ctrl;
    localparam int N = 16;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         commit = 1'b0;
    logic [W-1:0] pc = '0;
    logic [N-1:0] pend = '0, en = '0, deleg = '0;
    logic         mgie = 1'b0, sgie = 1'b0;
    logic [1:0]   priv = 2'd3;

    logic         stall, clken, rvalid, rtrap;
    logic [W-1:0] rpc;
    logic         stall_n, clken_n, rvalid_n, rtrap_n;
    logic [W-1:0] rpc_n;

    int vectors = 0;
    int errors  = 0;

    bit           ref_wait = 1'b0;
    logic [W-1:0] ref_pc = '0;

    always #2 clk = ~clk;  // 250 MHz

    wfi_wake_ctrl #(.NUM_IRQ(N), .XLEN(W), .NOP_MODE(1'b0)) dut (
        .clk(clk), .rst(rst), .wfi_commit_i(commit), .wfi_pc_i(pc),
        .irq_pending_i(pend), .irq_enable_i(en), .irq_deleg_i(deleg),
        .m_gie_i(mgie), .s_gie_i(sgie), .priv_i(priv),
        .stall_o(stall), .clk_en_o(clken), .resume_valid_o(rvalid),
        .resume_trap_o(rtrap), .resume_pc_o(rpc));

    wfi_wake_ctrl #(.NUM_IRQ(N), .XLEN(W), .NOP_MODE(1'b1)) dut_nop (
        .clk(clk), .rst(rst), .wfi_commit_i(commit), .wfi_pc_i(pc),
        .irq_pending_i(pend), .irq_enable_i(en), .irq_deleg_i(deleg),
        .m_gie_i(mgie), .s_gie_i(sgie), .priv_i(priv),
        .stall_o(stall_n), .clk_en_o(clken_n), .resume_valid_o(rvalid_n),
        .resume_trap_o(rtrap_n), .resume_pc_o(rpc_n));

    function automatic bit model_wake();
        for (int i = 0; i < N; i++) if (pend[i] && en[i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit model_take();
        for (int i = 0; i < N; i++) begin
            if (pend[i] && en[i]) begin
                if (deleg[i]) begin
                    if (priv == 2'd0) return 1'b1;
                    if (priv == 2'd1 && sgie) return 1'b1;
                end else begin
                    if (priv != 2'd3 || mgie) return 1'b1;
                end
            end
        end
        return 1'b0;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Check at negedge+1, update the model, then wait for the next negedge.
    task automatic step();
        bit wk, tk, ev;
        #1;
        if (rst) begin
            chk("R10 stall", W'(stall), 0);
            chk("R10 clk_en", W'(clken), 1);
            chk("R10 resume_valid", W'(rvalid), 0);
            ref_wait = 1'b0;
        end else begin
            wk = model_wake();
            tk = model_take();
            ev = (ref_wait && wk) || (commit && !ref_wait && wk);
            chk("R2/R3 stall", W'(stall), W'(ref_wait && !wk));
            chk("R8 clk_en", W'(clken), W'(!ref_wait));
            chk("R3/R4 resume_valid", W'(rvalid), W'(ev));
            chk("R6/R7 resume_trap", W'(rtrap), W'(ev && tk));
            if (ev) chk("R5 resume_pc", rpc, (ref_wait ? ref_pc : pc) + 4);
            chk("R9 nop stall", W'(stall_n), 0);
            chk("R9 nop clk_en", W'(clken_n), 1);
            chk("R9 nop resume_valid", W'(rvalid_n), W'(commit));
            chk("R9 nop resume_trap", W'(rtrap_n), W'(commit && tk));
            if (commit) chk("R9 nop resume_pc", rpc_n, pc + 4);
            if (commit && !ref_wait && !wk) begin
                ref_wait = 1'b1;
                ref_pc   = pc;
            end else if (ref_wait && wk) begin
                ref_wait = 1'b0;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_commit(input logic [W-1:0] p);
        commit = 1'b1; pc = p;
        step();
        commit = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL R2 watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        idle(3);          // R10 under reset
        rst = 1'b0;
        idle(2);          // R10 after reset

        // R1/R7: wake in M with globals off, non-delegated -> fall-through
        priv = 2'd3; mgie = 0; sgie = 0; deleg = '0;
        do_commit(32'h0000_0100);
        idle(3);
        pend[3] = 1; en[3] = 1;
        step();
        pend = '0; en = '0; idle(1);

        // R1: pending but not enabled does not wake
        do_commit(32'h0000_0200);
        pend[4] = 1; idle(3);
        en[4] = 1; step();             // wake now; M, mgie=0 -> no trap
        pend = '0; en = '0; idle(1);

        // R1/R6: delegated source in M with sgie=1 wakes but is not taken
        deleg[5] = 1; sgie = 1;
        do_commit(32'h0000_0300);
        idle(2);
        pend[5] = 1; en[5] = 1; step();
        pend = '0; en = '0; idle(1);

        // R4/R6: already armed at commit in S, non-delegated -> trap at once
        priv = 2'd1; deleg = '0; pend[1] = 1; en[1] = 1;
        do_commit(32'h0000_0400);
        idle(2);
        pend = '0; en = '0;

        // R6: delegated in U -> trap
        priv = 2'd0; deleg[7] = 1; sgie = 0;
        do_commit(32'h0000_0500);
        idle(1);
        pend[7] = 1; en[7] = 1; step();
        pend = '0; en = '0;

        // R6: delegated in S, sgie 0 -> no trap; then sgie 1 -> trap
        priv = 2'd1;
        do_commit(32'h0000_0600);
        pend[7] = 1; en[7] = 1; step();
        pend = '0; en = '0;
        sgie = 1;
        do_commit(32'h0000_0700);
        pend[7] = 1; en[7] = 1; step();
        pend = '0; en = '0; idle(1);

        // R5: PC wraps at the top of the address space
        do_commit(32'hFFFF_FFFC);
        idle(2);
        pend[0] = 1; en[0] = 1; step();
        pend = '0; en = '0; idle(1);

        // Mixed random phase
        for (int k = 0; k < 3000; k++) begin
            commit = !ref_wait && ($urandom_range(0, 3) == 0);
            pc     = {$urandom_range(0, 32'h3FFF_FFFF), 2'b00};
            pend   = N'($urandom) & N'($urandom) & N'($urandom);
            en     = N'($urandom) & N'($urandom);
            deleg  = N'($urandom);
            mgie   = 1'($urandom);
            sgie   = 1'($urandom);
            priv   = 2'($urandom);
            step();
        end
        commit = 0; pend = '0; en = '0;
        idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule